// File: doc/BRIEF.md
# Character Cell Pixel Renderer

This block sits behind a raster timing generator in a text-mode display path. For each pixel clock it takes the current character cell (row and column), the line and column inside the 8x8 glyph, the active-window flag and the two sync levels. From these it produces one 6-bit RGB pixel together with sync outputs delayed by the same number of cycles. The screen is 32 cells wide and 16 cells tall. A character memory holds one code per cell and a colour memory holds one byte per cell, with a foreground and a background palette index. Both memories are written from outside through their own write ports while the raster reads them.

The pixel path has three registered stages. The first reads the two cell memories. The second reads the glyph row from a three-bank font store and maps both colour indices through 16-entry palette tables. The third picks foreground or background from the glyph bit, blanks outside the active window and registers the colour. A pixel-clock enable advances all three stages together.

Top module: `char_cell_renderer`

## Requirements
- R1: While reset is asserted, and for the first two enabled clock edges after release, `rgb_out`, `hsync_out` and `vsync_out` are all 0.
- R2: Both cell memories hold 512 bytes and are read at address `cell_row*32 + cell_col`. A write through `chr_we`/`clr_we` at an address is seen by every later read of that address.
- R3: When a write and a read hit the same cell in the same enabled cycle, the read returns the contents from before the write. The new value is returned from the next read on.
- R4: For a code c below 192 and glyph line r, the font row byte is `{c[4:0], r} XOR K`. K is 0x00 for codes 0–63, 0xFF for 64–127 and 0x5A for 128–191, and bits c[7:6] choose the bank.
- R5: Glyph column g uses bit 7−g of the font row byte, so column 0 is the most significant bit.
- R6: Codes 192–255 have an all-zero font row, so every pixel shows the background colour.
- R7: Colour byte bits 7:4 are the foreground index and bits 3:0 the background index. Both go through the same table: 0:00 1:3F 2:03 3:3C 4:33 5:0C 6:30 7:0F 8:07 9:01 A:17 B:15 C:2A D:1E E:39 F:2F (hex). The RGB value packs blue in 5:4, green in 3:2 and red in 1:0.
- R8: A font bit of 1 outputs the foreground colour and a font bit of 0 outputs the background colour.
- R9: A pixel presented with `active_in` = 0 comes out as `rgb_out` = 0, whatever the memory contents.
- R10: `rgb_out`, `hsync_out` and `vsync_out` reflect the inputs from exactly three enabled cycles earlier, so pixel and sync stay aligned.
- R11: While `pix_en` is 0 all three outputs hold their values and the pipeline does not advance. Memory writes are still accepted in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; advances the pipeline |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| active_in | input | 1 | High inside the active text window |
| cell_col | input | 5 | Character column 0–31 |
| cell_row | input | 4 | Character row 0–15 |
| glyph_row | input | 3 | Line inside the glyph, 0 is top |
| glyph_col | input | 3 | Pixel inside the glyph, 0 is left |
| chr_we | input | 1 | Character memory write enable |
| chr_waddr | input | 9 | Character memory write address |
| chr_wdata | input | 8 | Character code to write |
| clr_we | input | 1 | Colour memory write enable |
| clr_waddr | input | 9 | Colour memory write address |
| clr_wdata | input | 8 | Colour byte to write (fg 7:4, bg 3:0) |
| rgb_out | output | 6 | Registered pixel colour |
| hsync_out | output | 1 | Horizontal sync delayed to match pixels |
| vsync_out | output | 1 | Vertical sync delayed to match pixels |

## Verification
The hardest situation to create is a write to the exact cell being read in the same enabled cycle. In that case the pixel three cycles later must still show the old glyph, and the one after it the new glyph. The stimulus drives the write port and the read position together on one edge, picking a glyph line and column where the old and new codes give opposite font bits. A second awkward case is stopping the pipeline while three different pixels are in flight and writing memory during the stall. The bench freezes the enable in the middle of a pixel stream and then resumes. Every in-flight pixel must still come out in order, and the cell written during the stall must show its new code when read.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int RGB_W      = 6;
  localparam int PAL_IDX_W  = 4;
  localparam int FONT_W     = 8;
  localparam int GLYPH_IDXW = 6;   // glyphs per bank = 2**GLYPH_IDXW
  localparam int FONT_BANKS = 3;

  typedef struct packed {
    logic       hs;
    logic       vs;
    logic       act;
    logic [2:0] gcol;
  } ctl_t;

  // Shared 16-entry colour table, {blue, green, red} two bits each.
  function automatic logic [RGB_W-1:0] pal_lookup(input logic [PAL_IDX_W-1:0] idx);
    logic [RGB_W-1:0] v;
    case (idx)
      4'h0: v = 6'h00;
      4'h1: v = 6'h3F;
      4'h2: v = 6'h03;
      4'h3: v = 6'h3C;
      4'h4: v = 6'h33;
      4'h5: v = 6'h0C;
      4'h6: v = 6'h30;
      4'h7: v = 6'h0F;
      4'h8: v = 6'h07;
      4'h9: v = 6'h01;
      4'hA: v = 6'h17;
      4'hB: v = 6'h15;
      4'hC: v = 6'h2A;
      4'hD: v = 6'h1E;
      4'hE: v = 6'h39;
      default: v = 6'h2F;
    endcase
    return v;
  endfunction

  // Per-bank pattern key folded into the placeholder glyph bytes.
  function automatic logic [FONT_W-1:0] bank_key(input int k);
    logic [FONT_W-1:0] v;
    case (k)
      0:       v = 8'h00;
      1:       v = 8'hFF;
      default: v = 8'h5A;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ccr_dpram.sv
module ccr_dpram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q, rd_d;

  // Storage array: write port, no reset on contents.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read register: returns pre-write contents on a same-cycle collision.
  always_comb begin
    rd_d = rd_q;
    if (re) rd_d = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/ccr_font_rom.sv
module ccr_font_rom #(
  parameter int CODE_W = 8,
  parameter int ROW_W  = 3,
  parameter int IDX_W  = ccr_pkg::GLYPH_IDXW,
  parameter int BANKS  = ccr_pkg::FONT_BANKS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [CODE_W-1:0]         code,
  input  logic [ROW_W-1:0]          grow,
  output logic [ccr_pkg::FONT_W-1:0] row_bits
);

  localparam int BSEL_W = CODE_W - IDX_W;
  localparam int LA_W   = IDX_W + ROW_W;
  localparam int FW     = ccr_pkg::FONT_W;

  logic [LA_W-1:0]   laddr;
  logic [FW-1:0]     bank_q [BANKS];
  logic [BSEL_W-1:0] sel_q, sel_d;

  assign laddr = {code[IDX_W-1:0], grow};

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    logic [FW-1:0] q_q, q_d;

    always_comb begin
      q_d = q_q;
      if (en) q_d = laddr[FW-1:0] ^ ccr_pkg::bank_key(k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q <= '0;
      else        q_q <= q_d;
    end

    assign bank_q[k] = q_q;
  end

  always_comb begin
    sel_d = sel_q;
    if (en) sel_d = code[CODE_W-1:IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  // Bank multiplexer; selections past the last bank read as empty rows.
  always_comb begin
    row_bits = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (sel_q == BSEL_W'(k)) row_bits = bank_q[k];
    end
  end

endmodule

// File: rtl/ccr_palette.sv
module ccr_palette #(
  parameter int IDX_W = ccr_pkg::PAL_IDX_W,
  parameter int OUT_W = ccr_pkg::RGB_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_W-1:0] rgb
);

  always_comb rgb = ccr_pkg::pal_lookup(idx);

endmodule

// File: rtl/char_cell_renderer.sv
module char_cell_renderer #(
  parameter int COL_W  = 5,
  parameter int ROW_W  = 4,
  parameter int GROW_W = 3,
  parameter int GCOL_W = 3,
  parameter int CODE_W = 8,
  parameter int CLR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pix_en,
  input  logic                     hsync_in,
  input  logic                     vsync_in,
  input  logic                     active_in,
  input  logic [COL_W-1:0]         cell_col,
  input  logic [ROW_W-1:0]         cell_row,
  input  logic [GROW_W-1:0]        glyph_row,
  input  logic [GCOL_W-1:0]        glyph_col,
  input  logic                     chr_we,
  input  logic [COL_W+ROW_W-1:0]   chr_waddr,
  input  logic [CODE_W-1:0]        chr_wdata,
  input  logic                     clr_we,
  input  logic [COL_W+ROW_W-1:0]   clr_waddr,
  input  logic [CLR_W-1:0]         clr_wdata,
  output logic [ccr_pkg::RGB_W-1:0] rgb_out,
  output logic                     hsync_out,
  output logic                     vsync_out
);

  import ccr_pkg::*;

  localparam int ADDR_W   = COL_W + ROW_W;
  localparam int IDX_W    = PAL_IDX_W;
  localparam int GCOL_MAX = (1 << GCOL_W) - 1;

  // Stage 1: cell memory read
  logic [ADDR_W-1:0] rd_addr;
  logic [CODE_W-1:0] chr_q;
  logic [CLR_W-1:0]  clr_q;
  ctl_t              ctl1_q, ctl1_d;
  logic [GROW_W-1:0] grow1_q, grow1_d;

  // Stage 2: font and palette
  logic [FONT_W-1:0] font_row;
  logic [RGB_W-1:0]  fg_lut, bg_lut;
  ctl_t              ctl2_q, ctl2_d;
  logic [RGB_W-1:0]  fg2_q, fg2_d, bg2_q, bg2_d;

  // Stage 3: output register
  logic [RGB_W-1:0]  rgb_q, rgb_d;
  logic              hs3_q, hs3_d, vs3_q, vs3_d;
  logic [GCOL_W-1:0] bit_idx;
  logic              font_bit;

  assign rd_addr = {cell_row, cell_col};

  ccr_dpram #(.AW(ADDR_W), .DW(CODE_W)) i_chr_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (chr_we),
    .waddr (chr_waddr),
    .wdata (chr_wdata),
    .re    (pix_en),
    .raddr (rd_addr),
    .rdata (chr_q)
  );

  ccr_dpram #(.AW(ADDR_W), .DW(CLR_W)) i_clr_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (clr_we),
    .waddr (clr_waddr),
    .wdata (clr_wdata),
    .re    (pix_en),
    .raddr (rd_addr),
    .rdata (clr_q)
  );

  ccr_font_rom #(.CODE_W(CODE_W), .ROW_W(GROW_W)) i_font (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pix_en),
    .code     (chr_q),
    .grow     (grow1_q),
    .row_bits (font_row)
  );

  // Foreground from the high nibble, background from the low nibble.
  ccr_palette i_pal_fg (.idx(clr_q[CLR_W-1 -: IDX_W]), .rgb(fg_lut));
  ccr_palette i_pal_bg (.idx(clr_q[IDX_W-1:0]),        .rgb(bg_lut));

  assign bit_idx  = GCOL_W'(GCOL_MAX) - ctl2_q.gcol;
  assign font_bit = font_row[bit_idx];

  always_comb begin
    ctl1_d  = ctl1_q;
    grow1_d = grow1_q;
    ctl2_d  = ctl2_q;
    fg2_d   = fg2_q;
    bg2_d   = bg2_q;
    rgb_d   = rgb_q;
    hs3_d   = hs3_q;
    vs3_d   = vs3_q;
    if (pix_en) begin
      ctl1_d.hs   = hsync_in;
      ctl1_d.vs   = vsync_in;
      ctl1_d.act  = active_in;
      ctl1_d.gcol = glyph_col;
      grow1_d     = glyph_row;
      ctl2_d      = ctl1_q;
      fg2_d       = fg_lut;
      bg2_d       = bg_lut;
      rgb_d       = ctl2_q.act ? (font_bit ? fg2_q : bg2_q) : '0;
      hs3_d       = ctl2_q.hs;
      vs3_d       = ctl2_q.vs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q  <= '0;
      grow1_q <= '0;
      ctl2_q  <= '0;
      fg2_q   <= '0;
      bg2_q   <= '0;
      rgb_q   <= '0;
      hs3_q   <= 1'b0;
      vs3_q   <= 1'b0;
    end else begin
      ctl1_q  <= ctl1_d;
      grow1_q <= grow1_d;
      ctl2_q  <= ctl2_d;
      fg2_q   <= fg2_d;
      bg2_q   <= bg2_d;
      rgb_q   <= rgb_d;
      hs3_q   <= hs3_d;
      vs3_q   <= vs3_d;
    end
  end

  assign rgb_out   = rgb_q;
  assign hsync_out = hs3_q;
  assign vsync_out = vs3_q;

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic       hsync_in,
  input logic       vsync_in,
  input logic       active_in,
  input logic [5:0] rgb_out,
  input logic       hsync_out,
  input logic       vsync_out
);

  logic [1:0] n_en;
  logic [2:0] act_d, hs_d, vs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_en  <= '0;
      act_d <= '0;
      hs_d  <= '0;
      vs_d  <= '0;
    end else if (pix_en) begin
      if (n_en != 2'd3) n_en <= n_en + 2'd1;
      act_d <= {act_d[1:0], active_in};
      hs_d  <= {hs_d[1:0], hsync_in};
      vs_d  <= {vs_d[1:0], vsync_in};
    end
  end

  // R1: outputs quiet until the pipeline has filled.
  p_fill_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (n_en != 2'd3) |-> (rgb_out == 6'd0 && !hsync_out && !vsync_out));

  // R9: a pixel entered outside the window leaves as black.
  p_blank_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_d[2] |-> (rgb_out == 6'd0));

  // R10: syncs emerge three enabled cycles after entry.
  p_hsync_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_out == hs_d[2]);

  p_vsync_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out == vs_d[2]);

  // R11: a disabled cycle leaves all outputs unchanged.
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(rgb_out) && $stable(hsync_out) && $stable(vsync_out)));

endmodule

bind char_cell_renderer ccr_checker i_ccr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_en    (pix_en),
  .hsync_in  (hsync_in),
  .vsync_in  (vsync_in),
  .active_in (active_in),
  .rgb_out   (rgb_out),
  .hsync_out (hsync_out),
  .vsync_out (vsync_out)
);

// File: tb/test_char_cell_renderer.sv
module test_char_cell_renderer;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en;
  logic       hsync_in, vsync_in, active_in;
  logic [4:0] cell_col;
  logic [3:0] cell_row;
  logic [2:0] glyph_row, glyph_col;
  logic       chr_we, clr_we;
  logic [8:0] chr_waddr, clr_waddr;
  logic [7:0] chr_wdata, clr_wdata;
  logic [5:0] rgb_out;
  logic       hsync_out, vsync_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_chr [512];
  logic [7:0] m_clr [512];

  logic [5:0] e_rgb [3];
  logic       e_hs  [3];
  logic       e_vs  [3];
  logic       e_v   [3];
  string      e_tag [3];

  always #(CLK_P/2) clk = ~clk;

  char_cell_renderer i_char_cell_renderer (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .active_in(active_in),
    .cell_col(cell_col), .cell_row(cell_row),
    .glyph_row(glyph_row), .glyph_col(glyph_col),
    .chr_we(chr_we), .chr_waddr(chr_waddr), .chr_wdata(chr_wdata),
    .clr_we(clr_we), .clr_waddr(clr_waddr), .clr_wdata(clr_wdata),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  function automatic logic [5:0] pal(input logic [3:0] i);
    logic [5:0] t [16] = '{6'h00, 6'h3F, 6'h03, 6'h3C, 6'h33, 6'h0C, 6'h30, 6'h0F,
                           6'h07, 6'h01, 6'h17, 6'h15, 6'h2A, 6'h1E, 6'h39, 6'h2F};
    return t[i];
  endfunction

  function automatic logic [7:0] font(input logic [7:0] c, input logic [2:0] r);
    logic [7:0] k;
    if (c >= 8'd192) return 8'h00;
    k = (c < 8'd64) ? 8'h00 : (c < 8'd128) ? 8'hFF : 8'h5A;
    return {c[4:0], r} ^ k;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (rgb,hs,vs)", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    hsync_in = 0; vsync_in = 0; active_in = 0;
    cell_col = 0; cell_row = 0; glyph_row = 0; glyph_col = 0;
    chr_we = 0; clr_we = 0; chr_waddr = 0; clr_waddr = 0;
    chr_wdata = 0; clr_wdata = 0;
  endtask

  // Memory write with the pipeline stalled.
  task automatic wr_cell(input logic [3:0] r, input logic [4:0] c,
                         input logic [7:0] code, input logic [7:0] colr);
    @(negedge clk);
    pix_en = 0;
    chr_we = 1; chr_waddr = {r, c}; chr_wdata = code;
    clr_we = 1; clr_waddr = {r, c}; clr_wdata = colr;
    m_chr[{r, c}] = code;
    m_clr[{r, c}] = colr;
  endtask

  // One enabled pixel; checks the pixel issued three steps earlier.
  task automatic step(input string tag, input logic act, input logic hs, input logic vs,
                      input logic [3:0] r, input logic [4:0] c,
                      input logic [2:0] gr, input logic [2:0] gc,
                      input logic wen = 1'b0, input logic [7:0] wd = 8'h00);
    logic [8:0] a;
    logic [7:0] code, colr, fb;
    logic       b;
    @(negedge clk);
    if (e_v[2]) chk(e_tag[2], {rgb_out, hsync_out, vsync_out}, {e_rgb[2], e_hs[2], e_vs[2]});
    for (int i = 2; i > 0; i--) begin
      e_rgb[i] = e_rgb[i-1]; e_hs[i] = e_hs[i-1]; e_vs[i] = e_vs[i-1];
      e_v[i] = e_v[i-1]; e_tag[i] = e_tag[i-1];
    end
    a    = {r, c};
    code = m_chr[a];
    colr = m_clr[a];
    fb   = font(code, gr);
    b    = fb[3'd7 - gc];
    e_rgb[0] = act ? (b ? pal(colr[7:4]) : pal(colr[3:0])) : 6'h00;
    e_hs[0] = hs; e_vs[0] = vs; e_v[0] = 1; e_tag[0] = tag;
    pix_en = 1;
    active_in = act; hsync_in = hs; vsync_in = vs;
    cell_row = r; cell_col = c; glyph_row = gr; glyph_col = gc;
    chr_we = wen; chr_waddr = a; chr_wdata = wd;
    clr_we = 0;
    if (wen) m_chr[a] = wd;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 3; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; pix_en = 0; idle_inputs();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      hsync_in = 1; vsync_in = 1; active_in = 1;
      chk("R1 in reset", {rgb_out, hsync_out, vsync_out}, 8'h00);
    end
    @(negedge clk);
    rst_n = 1;
    idle_inputs();
    for (int i = 0; i < 3; i++) begin
      e_rgb[i] = 0; e_hs[i] = 0; e_vs[i] = 0; e_v[i] = 1; e_tag[i] = "R1 fill";
    end
  endtask

  task automatic t_clear_mem();
    for (int a = 0; a < 512; a++) wr_cell(a[8:5], a[4:0], 8'hC0, 8'h00);
  endtask

  task automatic t_address();
    wr_cell(0, 0, 8'hC8, 8'h01);
    wr_cell(0, 31, 8'hC8, 8'h02);
    wr_cell(15, 0, 8'hC8, 8'h03);
    wr_cell(15, 31, 8'hC8, 8'h04);
    wr_cell(7, 19, 8'hC8, 8'h05);
    wr_cell(7, 20, 8'hC8, 8'h06);
    step("R2 cell 0,0",   1, 0, 0, 0, 0, 0, 0);
    step("R2 cell 0,31",  1, 0, 0, 0, 31, 0, 0);
    step("R2 cell 15,0",  1, 0, 0, 15, 0, 0, 0);
    step("R2 cell 15,31", 1, 0, 0, 15, 31, 0, 0);
    step("R2 cell 7,19",  1, 0, 0, 7, 19, 0, 0);
    step("R2 cell 7,20",  1, 0, 0, 7, 20, 0, 0);
    flush("R2 flush");
  endtask

  task automatic t_font();
    logic [7:0] codes [3] = '{8'h05, 8'h41, 8'h9C};
    logic [2:0] rows  [3] = '{3'd0, 3'd5, 3'd7};
    for (int k = 0; k < 3; k++) wr_cell(2, 5'(k), codes[k], 8'h10);
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 3; r++)
        for (int g = 0; g < 8; g++)
          step("R4/R5/R8 glyph bits", 1, 0, 0, 2, 5'(k), rows[r], 3'(g));
    flush("R4 flush");
  endtask

  task automatic t_high_codes();
    wr_cell(3, 0, 8'hC5, 8'h2E);
    wr_cell(3, 1, 8'hFF, 8'h2E);
    for (int k = 0; k < 2; k++)
      for (int g = 0; g < 8; g++)
        step("R6 upper codes", 1, 0, 0, 3, 5'(k), 3'd3, 3'(g));
    flush("R6 flush");
  endtask

  task automatic t_palette();
    for (int i = 0; i < 16; i++) wr_cell(5, 5'(i), 8'h3F, {4'(i), 4'(15 - i)});
    for (int i = 0; i < 16; i++)
      for (int g = 0; g < 8; g++)
        step("R7 palette", 1, 0, 0, 5, 5'(i), 3'd1, 3'(g));
    flush("R7 flush");
  endtask

  task automatic t_blank();
    for (int i = 0; i < 16; i++) step("R9 blank", 0, 0, 0, 5, 5'(i), 3'd1, 3'(i));
    flush("R9 flush");
  endtask

  task automatic t_sync();
    for (int i = 0; i < 12; i++)
      step("R10 sync align", (i % 3) != 0, i[0], i[2], 5, 5'(i), 3'd2, 3'(i));
    flush("R10 flush");
  endtask

  task automatic t_collide();
    wr_cell(9, 9, 8'h41, 8'h10);
    step("R3 read old on collision", 1, 0, 0, 9, 9, 3'd2, 3'd3, 1'b1, 8'h05);
    step("R3 read new after write",  1, 0, 0, 9, 9, 3'd2, 3'd3);
    flush("R3 flush");
  endtask

  task automatic t_stall();
    logic [7:0] snap;
    wr_cell(11, 4, 8'h41, 8'h1D);
    wr_cell(11, 5, 8'h9C, 8'hB2);
    step("R11 pre", 1, 1, 0, 11, 4, 3'd0, 3'd0);
    step("R11 pre", 1, 0, 1, 11, 5, 3'd1, 3'd2);
    step("R11 pre", 1, 1, 1, 11, 4, 3'd4, 3'd6);
    @(negedge clk);
    snap = {rgb_out, hsync_out, vsync_out};
    pix_en = 0;
    active_in = 1; hsync_in = 1; vsync_in = 1; cell_row = 0; cell_col = 0;
    chr_we = 1; chr_waddr = {4'd11, 5'd6}; chr_wdata = 8'h05;
    clr_we = 1; clr_waddr = {4'd11, 5'd6}; clr_wdata = 8'h10;
    m_chr[{4'd11, 5'd6}] = 8'h05;
    m_clr[{4'd11, 5'd6}] = 8'h10;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chr_we = 0; clr_we = 0;
      chk("R11 hold while stalled", {rgb_out, hsync_out, vsync_out}, snap);
    end
    step("R11 resume", 1, 0, 0, 11, 6, 3'd2, 3'd2);
    step("R11 resume", 1, 0, 0, 11, 6, 3'd2, 3'd3);
    flush("R11 flush");
  endtask

  initial begin
    t_reset();
    t_clear_mem();
    t_address();
    t_font();
    t_high_codes();
    t_palette();
    t_blank();
    t_sync();
    t_collide();
    t_stall();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule